// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is an 8-bit timer channel that counts up from zero to its ceiling of 0xFF and then back down to zero, without stopping. It drives one PWM output from a compare value. The counter moves only in clock cycles where an external prescaler raises the `tick` enable. Because the counter sweeps in both directions, a full output period is 510 ticks. The pulse is therefore centred on the zero point of the count, and its phase does not move when the compare value changes.

Software-side logic writes a new compare value into a holding register. The channel copies it into the active comparator only at the moment the count reaches its ceiling, so a period never mixes an old edge with a new one.

A 2-bit mode input selects one of three behaviours: a high-true pulse, a low-true pulse, or a frozen output. Compare values of zero and 0xFF produce steady levels. A forced update at the ceiling keeps the waveform symmetric when a rising-side match was skipped. Two one-cycle event outputs mark arrival at the ceiling and at zero.

Top module: `pcpwm_channel`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge leaves `cnt_o`=0, the counting direction up, `pwm_o`=0, and both event outputs 0.
- R2: On each edge with `tick`=1 the count moves one step. It climbs 0,1,…,255 and then descends 254,…,0, then climbs again, so one period is 510 ticks.
- R3: `top_evt` is 1 for exactly the one cycle after the tick that brings the count to 255. `bot_evt` is 1 for exactly the one cycle after the tick that brings it to 0.
- R4: With `out_mode`=2 (high-true), a tick landing on the active compare value A (0<A<255) drives `pwm_o` low while rising and high while falling. The high time is therefore 2·A ticks per period.
- R5: With `out_mode`=3 (low-true), the levels of R4 are reversed. The high time is 510−2·A ticks per period.
- R6: A=0 gives a steady low in mode 2 and a steady high in mode 3. A=255 gives a steady high in mode 2 and a steady low in mode 3.
- R7: A write strobe `cmp_wr` stores `cmp_wdata` in a holding register. The active compare value takes the held value only on the tick that brings the count to 255. Until then the old value still sets both edges.
- R8: With `out_mode` 0 or 1, `pwm_o` holds its current level whatever the count and compare value do.
- R9: On the tick that reaches 255 in mode 2 or 3, `pwm_o` takes the rising-match level (mode 2: low, mode 3: high) unless the newly loaded value is 255. This happens even without a match, for example after the compare value leaves 255, or after the rising match was skipped.
- R10: On edges with `tick`=0 the count, the direction and `pwm_o` do not change, and no event output pulses.
- R11: Asserting `rst` while the channel is running returns it to the R1 state at the next edge. Counting restarts from 1 on the first tick after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-clock enable from the prescaler |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to hold |
| out_mode | input | 2 | 0/1 freeze output, 2 high-true PWM, 3 low-true PWM |
| cnt_o | output | 8 | Current count |
| pwm_o | output | 1 | PWM output |
| top_evt | output | 1 | One-cycle pulse on reaching 255 |
| bot_evt | output | 1 | One-cycle pulse on reaching 0 |

## Verification
The main function is exercised with compare values at mid-scale (100), next to each extreme (1 and 254), and at both extremes, in both polarities. Measuring the high time over exactly one period from the ceiling separates an off-by-one in the match position from a swapped polarity and from a missing constant-level case.

A compare value written just after the ceiling is checked against both edges of the following descent and ascent. This shows whether the holding register leaks into the active comparator too early.

Two further patterns cover the forced update at the ceiling: a compare value leaving 255, and a switch into low-true mode after the rising match has passed. A sparse tick pattern and a freeze mode show that nothing moves without an enable.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  typedef enum logic [1:0] {
    OM_FREEZE_A = 2'd0,
    OM_FREEZE_B = 2'd1,
    OM_HIGHTRUE = 2'd2,
    OM_LOWTRUE  = 2'd3
  } om_e;

  // True when the mode lets compare events move the output.
  function automatic logic om_drives(input om_e m);
    return (m == OM_HIGHTRUE) || (m == OM_LOWTRUE);
  endfunction

  // Output level produced by a match while the count rises.
  function automatic logic lvl_on_rise(input om_e m);
    return (m == OM_LOWTRUE);
  endfunction

  // Output level produced by a match while the count falls.
  function automatic logic lvl_on_fall(input om_e m);
    return (m == OM_HIGHTRUE);
  endfunction

endpackage

// File: rtl/pcpwm_ramp.sv
module pcpwm_ramp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic         up_q,
  output logic [W-1:0] cnt_nxt,
  output logic         hit_top,
  output logic         hit_bot,
  output logic         top_evt,
  output logic         bot_evt
);

  localparam logic [W-1:0] CEIL  = {W{1'b1}};
  localparam logic [W-1:0] FLOOR = '0;

  always_comb begin
    cnt_nxt = up_q ? (cnt_q + 1'b1) : (cnt_q - 1'b1);
    hit_top = tick && (cnt_nxt == CEIL);
    hit_bot = tick && (cnt_nxt == FLOOR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= FLOOR;
      up_q    <= 1'b1;
      top_evt <= 1'b0;
      bot_evt <= 1'b0;
    end else begin
      top_evt <= hit_top;
      bot_evt <= hit_bot;
      if (tick) begin
        cnt_q <= cnt_nxt;
        if (hit_top)      up_q <= 1'b0;
        else if (hit_bot) up_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcpwm_cmpbuf.sv
module pcpwm_cmpbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] act_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr)   pend_q <= wdata;
      if (load) act_q  <= pend_q;
    end
  end

endmodule

// File: rtl/pcpwm_wave.sv
module pcpwm_wave
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  om_e          mode,
  input  logic [W-1:0] cnt_nxt,
  input  logic         up_q,
  input  logic         hit_top,
  input  logic [W-1:0] act_q,
  input  logic [W-1:0] pend_q,
  output logic         rise_match,
  output logic         fall_match,
  output logic         pwm_q
);

  localparam logic [W-1:0] CEIL = {W{1'b1}};

  logic top_lvl;
  logic pwm_n;
  logic act_nonzero;

  always_comb begin
    act_nonzero = (act_q != '0);
    rise_match  = tick && up_q && !hit_top && (cnt_nxt == act_q) && act_nonzero;
    fall_match  = tick && !up_q && (cnt_nxt == act_q) && act_nonzero;
    // At the ceiling the freshly loaded value decides: 255 means steady level.
    top_lvl     = (pend_q == CEIL) ? lvl_on_fall(mode) : lvl_on_rise(mode);
    pwm_n       = pwm_q;
    if (om_drives(mode)) begin
      if (hit_top)         pwm_n = top_lvl;
      else if (rise_match) pwm_n = lvl_on_rise(mode);
      else if (fall_match) pwm_n = lvl_on_fall(mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_n;
  end

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   out_mode,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o,
  output logic         top_evt,
  output logic         bot_evt
);

  logic [W-1:0] cnt_nxt;
  logic         up_q;
  logic         top_hit;
  logic         bot_hit;
  logic [W-1:0] cmp_pend;
  logic [W-1:0] cmp_act;
  logic         rise_match;
  logic         fall_match;
  om_e          mode;

  assign mode = om_e'(out_mode);

  pcpwm_ramp #(.W(W)) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt_q   (cnt_o),
    .up_q    (up_q),
    .cnt_nxt (cnt_nxt),
    .hit_top (top_hit),
    .hit_bot (bot_hit),
    .top_evt (top_evt),
    .bot_evt (bot_evt)
  );

  pcpwm_cmpbuf #(.W(W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .wr     (cmp_wr),
    .wdata  (cmp_wdata),
    .load   (top_hit),
    .pend_q (cmp_pend),
    .act_q  (cmp_act)
  );

  pcpwm_wave #(.W(W)) u_wave (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode       (mode),
    .cnt_nxt    (cnt_nxt),
    .up_q       (up_q),
    .hit_top    (top_hit),
    .act_q      (cmp_act),
    .pend_q     (cmp_pend),
    .rise_match (rise_match),
    .fall_match (fall_match),
    .pwm_q      (pwm_o)
  );

endmodule

// File: rtl/pcpwm_sva.sv
module pcpwm_sva #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [1:0]   out_mode,
  input logic [W-1:0] cnt_o,
  input logic         pwm_o,
  input logic         top_evt,
  input logic         bot_evt,
  input logic         top_hit,
  input logic [W-1:0] cmp_pend
);

  localparam logic [W-1:0] CEIL = {W{1'b1}};

  a_r3_top_flag: assert property (@(posedge clk) disable iff (rst)
    top_evt |-> (cnt_o == CEIL));

  a_r3_bot_flag: assert property (@(posedge clk) disable iff (rst)
    bot_evt |-> (cnt_o == '0));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (((cnt_o - $past(cnt_o)) == W'(1)) || (($past(cnt_o) - cnt_o) == W'(1))));

  a_r10_hold_count: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt_o) && $stable(pwm_o) && !top_evt && !bot_evt));

  a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_mode[1] == 1'b0) |=> $stable(pwm_o));

  a_r9_top_hightrue: assert property (@(posedge clk) disable iff (rst)
    (top_hit && out_mode == 2'd2 && cmp_pend != CEIL) |=> !pwm_o);

  a_r9_top_lowtrue: assert property (@(posedge clk) disable iff (rst)
    (top_hit && out_mode == 2'd3 && cmp_pend != CEIL) |=> pwm_o);

  a_r6_ceiling_steady: assert property (@(posedge clk) disable iff (rst)
    (top_hit && out_mode == 2'd2 && cmp_pend == CEIL) |=> pwm_o);

endmodule

bind pcpwm_channel pcpwm_sva #(.W(W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .out_mode (out_mode),
  .cnt_o    (cnt_o),
  .pwm_o    (pwm_o),
  .top_evt  (top_evt),
  .bot_evt  (bot_evt),
  .top_hit  (top_hit),
  .cmp_pend (cmp_pend)
);

// File: tb/test_pcpwm_channel.sv
module test_pcpwm_channel;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic [1:0] out_mode = 2'd0;
  logic [7:0] cnt_o;
  logic       pwm_o;
  logic       top_evt;
  logic       bot_evt;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcpwm_channel i_pcpwm_channel (
    .clk(clk), .rst(rst), .tick(tick), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .out_mode(out_mode), .cnt_o(cnt_o), .pwm_o(pwm_o),
    .top_evt(top_evt), .bot_evt(bot_evt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) got=%0d exp=<%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", rq, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_top();
    do step(1); while (top_evt !== 1'b1);
  endtask

  task automatic wait_bot();
    do step(1); while (bot_evt !== 1'b1);
  endtask

  task automatic wait_cnt(input int v);
    do step(1); while (cnt_o != 8'(v));
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata = 8'(v);
    cmp_wr    = 1'b1;
    step(1);
    cmp_wr    = 1'b0;
  endtask

  task automatic measure(output int h);
    h = 0;
    for (int i = 0; i < 510; i++) begin
      if (pwm_o) h++;
      step(1);
    end
  endtask

  function automatic int tri_val(input int k);
    int e = k % 510;
    return (e <= 255) ? e : 510 - e;
  endfunction

  // R1: state held during reset
  task automatic t_reset();
    step(3);
    chk(cnt_o == 8'd0, "R1 count", cnt_o, 0);
    chk(pwm_o == 1'b0, "R1 pwm", pwm_o, 0);
    chk(top_evt == 1'b0, "R1 top_evt", top_evt, 0);
    chk(bot_evt == 1'b0, "R1 bot_evt", bot_evt, 0);
    rst  = 1'b0;
    tick = 1'b1;
  endtask

  // R2 and R3: triangle sequence and event pulses over two periods
  task automatic t_sequence();
    for (int k = 1; k <= 1020; k++) begin
      int v;
      step(1);
      v = tri_val(k);
      chk(cnt_o == 8'(v), "R2 count", cnt_o, v);
      chk(top_evt == (v == 255), "R3 top_evt", top_evt, int'(v == 255));
      chk(bot_evt == (v == 0), "R3 bot_evt", bot_evt, int'(v == 0));
    end
  endtask

  // R4 / R5 / R6: high time over one period after the new value is active
  task automatic t_duty(input int m, input int a, input int exp, input string rq);
    int h;
    wait_top();
    out_mode = 2'(m);
    wr_cmp(a);
    wait_top();
    measure(h);
    chk(h == exp, rq, h, exp);
  endtask

  // R7: the held value stays out of the comparator until the ceiling
  task automatic t_buffer();
    int h;
    t_duty(2, 100, 200, "R4 mode2 A=100");
    wr_cmp(20);
    wait_cnt(101);
    chk(pwm_o == 1'b0, "R7 old value above fall edge", pwm_o, 0);
    step(1);
    chk(pwm_o == 1'b1, "R7 old value sets fall edge", pwm_o, 1);
    wait_bot();
    wait_cnt(21);
    chk(pwm_o == 1'b1, "R7 new value not yet active", pwm_o, 1);
    wait_top();
    measure(h);
    chk(h == 40, "R7 new value after ceiling", h, 40);
  endtask

  // R8: freeze modes keep the level
  task automatic t_freeze();
    int h;
    wait_cnt(10);
    chk(pwm_o == 1'b1, "R8 level before freeze", pwm_o, 1);
    out_mode = 2'd1;
    measure(h);
    chk(h == 510, "R8 mode1 holds high", h, 510);
    out_mode = 2'd0;
    measure(h);
    chk(h == 510, "R8 mode0 holds high", h, 510);
  endtask

  // R9: forced level at the ceiling without a match
  task automatic t_top_force();
    t_duty(2, 255, 510, "R6 mode2 A=255");
    wr_cmp(50);
    chk(pwm_o == 1'b1, "R9 still high after write", pwm_o, 1);
    wait_bot();
    wait_cnt(254);
    chk(pwm_o == 1'b1, "R9 high before ceiling", pwm_o, 1);
    step(1);
    chk(top_evt == 1'b1, "R9 at ceiling", top_evt, 1);
    chk(pwm_o == 1'b0, "R9 forced low leaving 255", pwm_o, 0);
    out_mode = 2'd0;
    wait_bot();
    chk(pwm_o == 1'b0, "R8 frozen through descent", pwm_o, 0);
    wait_cnt(100);
    out_mode = 2'd3;
    wait_cnt(200);
    chk(pwm_o == 1'b0, "R9 rising match skipped", pwm_o, 0);
    wait_top();
    chk(pwm_o == 1'b1, "R9 forced high at ceiling", pwm_o, 1);
  endtask

  // R10: sparse ticks
  task automatic t_tick_gate();
    int   tops = 0;
    int   bots = 0;
    logic [7:0] prev;
    logic prev_top = 1'b0;
    for (int i = 0; i < 1530; i++) begin
      bit t;
      t    = (i % 3) == 0;
      tick = t;
      prev = cnt_o;
      step(1);
      if (t) chk(cnt_o != prev, "R10 moves on tick", cnt_o, 999);
      else   chk(cnt_o == prev, "R10 holds without tick", cnt_o, prev);
      if (!t) chk(!top_evt && !bot_evt, "R10 no event without tick", int'(top_evt | bot_evt), 0);
      chk(!(prev_top && top_evt), "R3 top_evt single cycle", 1, 0);
      prev_top = top_evt;
      if (top_evt) tops++;
      if (bot_evt) bots++;
    end
    chk(tops == 1, "R10 one ceiling per 510 ticks", tops, 1);
    chk(bots == 1, "R10 one floor per 510 ticks", bots, 1);
    tick = 1'b1;
  endtask

  // R11: reset while running
  task automatic t_mid_reset();
    t_duty(3, 0, 510, "R6 mode3 A=0");
    wait_cnt(77);
    chk(pwm_o == 1'b1, "R11 high before reset", pwm_o, 1);
    rst = 1'b1;
    step(1);
    chk(cnt_o == 8'd0, "R11 count cleared", cnt_o, 0);
    chk(pwm_o == 1'b0, "R11 pwm cleared", pwm_o, 0);
    rst = 1'b0;
    step(1);
    chk(cnt_o == 8'd1, "R11 restart from 1", cnt_o, 1);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_duty(2, 100, 200, "R4 mode2 A=100");
    t_duty(2, 1,   2,   "R4 mode2 A=1");
    t_duty(2, 254, 508, "R4 mode2 A=254");
    t_duty(3, 100, 310, "R5 mode3 A=100");
    t_duty(3, 1,   508, "R5 mode3 A=1");
    t_duty(2, 0,   0,   "R6 mode2 A=0");
    t_duty(2, 255, 510, "R6 mode2 A=255");
    t_duty(3, 0,   510, "R6 mode3 A=0");
    t_duty(3, 255, 0,   "R6 mode3 A=255");
    t_buffer();
    t_freeze();
    t_top_force();
    t_tick_gate();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule